// File: doc/BRIEF.md
# Adaptive-Threshold Integrate-and-Fire Neuron

This block is one digital leaky integrate-and-fire neuron. On every cycle where the time-step enable is high, it leaks its membrane value toward rest, adds a signed synaptic sum, and fires when the result is strictly above its own firing threshold. After a spike the membrane is parked at the reset value for a fixed number of steps. The spike pulse, the membrane value and the threshold are all registered outputs, so that learning logic next to the neuron can compare the membrane against levels derived from the threshold.

The threshold adapts in coarse fixed steps, and only on steps where the neuron fires. An activity estimate is kept as the number of spikes counted over a window of steps whose length is set by a pin. At each firing the estimate from the last completed window is compared with an upper and a lower count level. Above the upper level the threshold rises by one step. Below the lower level it falls by one step. The threshold always stays within clamped limits.

Values use unsigned fixed point with 16 LSBs per 0.025 threshold unit. With the default parameters the threshold therefore spans 80 (0.125) to 256 (0.4) and starts at 128 (0.2).

Top module: `adaptive_lif_neuron`

## Requirements
- R1: A synchronous active-high reset sets the membrane to 0, the threshold to THR_INIT (128), the spike output to 0 and clears the refractory, window and spike counters and the activity estimate.
- R2: On a cycle with step_en low, the membrane, threshold and all counters keep their values, the input is ignored and spike is 0 on the next cycle.
- R3: On a non-refractory step the new membrane is mem - (mem >> LEAK_SHIFT) + syn_in (LEAK_SHIFT = 3), with syn_in a two's-complement value; a result below 0 becomes 0.
- R4: When that result is strictly greater than the current threshold, spike is 1 for exactly the next cycle and the membrane becomes V_RESET (0); a result equal to the threshold does not fire.
- R5: For REFR_STEPS (2) steps after a firing step, the membrane stays at V_RESET and the neuron cannot fire, whatever syn_in is.
- R6: The sum saturates at the membrane maximum instead of wrapping, so a large positive input fires the neuron even when the wrapped sum would be below the threshold.
- R7: The activity estimate is the number of firings in the last completed window of win_len steps (a window closes on the step that brings its step count to win_len); before the first window closes it is 0.
- R8: On a firing step with activity greater than act_hi, the threshold rises by THR_STEP (16), clamped at THR_MAX (256).
- R9: On a firing step with activity less than act_lo, the threshold falls by THR_STEP, clamped at THR_MIN (80).
- R10: The threshold does not change on a step without firing, nor on a firing step whose activity lies between act_lo and act_hi inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | One neuron time step is taken on this cycle |
| syn_in | input | IN_W | Signed synaptic input sum for this step |
| win_len | input | CNT_W | Activity window length in steps |
| act_hi | input | CNT_W | Upper activity level; above it the threshold rises |
| act_lo | input | CNT_W | Lower activity level; below it the threshold falls |
| spike | output | 1 | One-cycle spike pulse |
| mem_out | output | MEM_W | Current membrane value |
| thr_out | output | MEM_W | Current firing threshold |

## Verification
A wrong membrane update shows on mem_out one cycle after the faulty step, and it also moves the firing step, so spike is early, late or missing. A stuck or miscounted refractory counter shows as a nonzero membrane or a spike during the hold steps. A miscounted activity window or a wrong comparison only shows at the next firing, as a threshold that moves when it should hold or holds when it should move. The window-driven sequences therefore check thr_out after specific firings and again after long runs where the clamp must hold.

// File: rtl/lif_pkg.sv
package lif_pkg;
  // Outcome of the threshold rule on one step.
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;

  // Bits needed to count from 0 to n inclusive.
  function automatic int count_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction
endpackage

// File: rtl/lif_membrane.sv
module lif_membrane #(
  parameter int IN_W       = 12,
  parameter int MEM_W      = 9,
  parameter int LEAK_SHIFT = 3,
  parameter int REFR_STEPS = 2,
  parameter int V_RESET    = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_en,
  input  logic signed [IN_W-1:0] syn_in,
  input  logic [MEM_W-1:0]       thr,
  output logic                   fire,
  output logic [MEM_W-1:0]       mem_q
);
  localparam int BASE_W = (IN_W > MEM_W + 1) ? IN_W : MEM_W + 1;
  localparam int SUM_W  = BASE_W + 1;
  localparam int REFR_W = lif_pkg::count_bits(REFR_STEPS);
  localparam logic [MEM_W-1:0]  RESET_V = MEM_W'(V_RESET);
  localparam logic [REFR_W-1:0] REFR_V  = REFR_W'(REFR_STEPS);

  logic [REFR_W-1:0]       refr_q;
  logic [MEM_W-1:0]        leaked;
  logic signed [SUM_W-1:0] leak_ext;
  logic signed [SUM_W-1:0] in_ext;
  logic signed [SUM_W-1:0] sum_s;
  logic signed [SUM_W-1:0] max_s;
  logic [MEM_W-1:0]        next_mem;
  logic                    in_refr;

  always_comb begin
    leaked   = mem_q - (mem_q >> LEAK_SHIFT);
    leak_ext = $signed({{(SUM_W-MEM_W){1'b0}}, leaked});
    in_ext   = {{(SUM_W-IN_W){syn_in[IN_W-1]}}, syn_in};
    sum_s    = leak_ext + in_ext;
    max_s    = $signed({{(SUM_W-MEM_W){1'b0}}, {MEM_W{1'b1}}});
    if (sum_s < 0)
      next_mem = '0;
    else if (sum_s > max_s)
      next_mem = {MEM_W{1'b1}};
    else
      next_mem = sum_s[MEM_W-1:0];
    in_refr = (refr_q != '0);
    fire    = step_en && !in_refr && (next_mem > thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q  <= '0;
      refr_q <= '0;
    end else if (step_en) begin
      if (in_refr) begin
        mem_q  <= RESET_V;
        refr_q <= refr_q - REFR_W'(1);
      end else if (fire) begin
        mem_q  <= RESET_V;
        refr_q <= REFR_V;
      end else begin
        mem_q  <= next_mem;
      end
    end
  end

  // R2: an idle cycle leaves the membrane untouched
  assert_idle_mem_R2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(mem_q));

  // R5: a step taken while the refractory count runs parks the membrane
  assert_refr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && refr_q != '0) |=> (mem_q == RESET_V));

  // R5: no firing while refractory
  assert_refr_nofire_R5: assert property (@(posedge clk) disable iff (rst)
    (refr_q != '0) |-> !fire);
endmodule

// File: rtl/lif_activity.sv
module lif_activity #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             fire,
  input  logic [CNT_W-1:0] win_len,
  output logic [CNT_W-1:0] act_q
);
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] spk_cnt;
  logic [CNT_W-1:0] spk_next;
  logic [CNT_W:0]   win_next;
  logic             close_win;

  always_comb begin
    if (fire && spk_cnt != {CNT_W{1'b1}})
      spk_next = spk_cnt + CNT_W'(1);
    else
      spk_next = spk_cnt;
    win_next  = {1'b0, win_cnt} + (CNT_W+1)'(1);
    close_win = (win_next >= {1'b0, win_len});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      spk_cnt <= '0;
      act_q   <= '0;
    end else if (step_en) begin
      if (close_win) begin
        act_q   <= spk_next;
        spk_cnt <= '0;
        win_cnt <= '0;
      end else begin
        spk_cnt <= spk_next;
        win_cnt <= win_next[CNT_W-1:0];
      end
    end
  end

  // R7: the estimate only moves on a step
  assert_act_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(act_q));

  // R7: a window can never hold more firings than it has steps
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (spk_cnt <= win_cnt));
endmodule

// File: rtl/lif_threshold.sv
module lif_threshold #(
  parameter int MEM_W    = 9,
  parameter int CNT_W    = 8,
  parameter int THR_MIN  = 80,
  parameter int THR_MAX  = 256,
  parameter int THR_INIT = 128,
  parameter int THR_STEP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] act,
  input  logic [CNT_W-1:0] act_hi,
  input  logic [CNT_W-1:0] act_lo,
  output logic [MEM_W-1:0] thr_q
);
  import lif_pkg::*;

  localparam logic [MEM_W:0]   MAX_E  = (MEM_W+1)'(THR_MAX);
  localparam logic [MEM_W:0]   MIN_E  = (MEM_W+1)'(THR_MIN);
  localparam logic [MEM_W:0]   STEP_E = (MEM_W+1)'(THR_STEP);
  localparam logic [MEM_W-1:0] MAX_V  = MEM_W'(THR_MAX);
  localparam logic [MEM_W-1:0] MIN_V  = MEM_W'(THR_MIN);
  localparam logic [MEM_W-1:0] INIT_V = MEM_W'(THR_INIT);
  localparam logic [MEM_W-1:0] STEP_V = MEM_W'(THR_STEP);

  adj_e           adj;
  logic [MEM_W:0] up_sum;
  logic [MEM_W:0] dn_floor;
  logic [MEM_W-1:0] thr_up;
  logic [MEM_W-1:0] thr_dn;

  always_comb begin
    if (fire && act > act_hi)
      adj = ADJ_UP;
    else if (fire && act < act_lo)
      adj = ADJ_DOWN;
    else
      adj = ADJ_HOLD;

    up_sum   = {1'b0, thr_q} + STEP_E;
    dn_floor = MIN_E + STEP_E;
    thr_up   = (up_sum > MAX_E) ? MAX_V : up_sum[MEM_W-1:0];
    thr_dn   = ({1'b0, thr_q} < dn_floor) ? MIN_V : (thr_q - STEP_V);
  end

  always_ff @(posedge clk) begin
    if (rst)
      thr_q <= INIT_V;
    else begin
      unique case (adj)
        ADJ_UP:   thr_q <= thr_up;
        ADJ_DOWN: thr_q <= thr_dn;
        default:  thr_q <= thr_q;
      endcase
    end
  end

  // R8 / R9: the threshold never leaves its clamped range
  assert_thr_range_R8: assert property (@(posedge clk) disable iff (rst)
    (thr_q >= MIN_V) && (thr_q <= MAX_V));

  // R10: without a firing the threshold holds
  assert_thr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(thr_q));

  // R8: a rise never lowers the threshold
  assert_up_monotone_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && act > act_hi) |=> (thr_q >= $past(thr_q)));

  // R9: a fall never raises the threshold
  assert_dn_monotone_R9: assert property (@(posedge clk) disable iff (rst)
    (fire && act < act_lo && act <= act_hi) |=> (thr_q <= $past(thr_q)));
endmodule

// File: rtl/adaptive_lif_neuron.sv
module adaptive_lif_neuron #(
  parameter int IN_W       = 12,
  parameter int MEM_W      = 9,
  parameter int CNT_W      = 8,
  parameter int LEAK_SHIFT = 3,
  parameter int REFR_STEPS = 2,
  parameter int V_RESET    = 0,
  parameter int THR_MIN    = 80,
  parameter int THR_MAX    = 256,
  parameter int THR_INIT   = 128,
  parameter int THR_STEP   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_en,
  input  logic signed [IN_W-1:0] syn_in,
  input  logic [CNT_W-1:0]       win_len,
  input  logic [CNT_W-1:0]       act_hi,
  input  logic [CNT_W-1:0]       act_lo,
  output logic                   spike,
  output logic [MEM_W-1:0]       mem_out,
  output logic [MEM_W-1:0]       thr_out
);
  localparam logic [MEM_W-1:0] RESET_V = MEM_W'(V_RESET);

  logic             fire;
  logic             spike_q;
  logic [MEM_W-1:0] mem_q;
  logic [MEM_W-1:0] thr_q;
  logic [CNT_W-1:0] act_q;

  lif_membrane #(
    .IN_W(IN_W), .MEM_W(MEM_W), .LEAK_SHIFT(LEAK_SHIFT),
    .REFR_STEPS(REFR_STEPS), .V_RESET(V_RESET)
  ) u_mem (
    .clk(clk), .rst(rst), .step_en(step_en), .syn_in(syn_in),
    .thr(thr_q), .fire(fire), .mem_q(mem_q)
  );

  lif_activity #(
    .CNT_W(CNT_W)
  ) u_act (
    .clk(clk), .rst(rst), .step_en(step_en), .fire(fire),
    .win_len(win_len), .act_q(act_q)
  );

  lif_threshold #(
    .MEM_W(MEM_W), .CNT_W(CNT_W), .THR_MIN(THR_MIN), .THR_MAX(THR_MAX),
    .THR_INIT(THR_INIT), .THR_STEP(THR_STEP)
  ) u_thr (
    .clk(clk), .rst(rst), .fire(fire), .act(act_q),
    .act_hi(act_hi), .act_lo(act_lo), .thr_q(thr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) spike_q <= 1'b0;
    else     spike_q <= fire;
  end

  assign spike   = spike_q;
  assign mem_out = mem_q;
  assign thr_out = thr_q;

  // R4: a spike is always seen together with the reset membrane
  assert_spike_reset_R4: assert property (@(posedge clk) disable iff (rst)
    spike_q |-> (mem_q == RESET_V));

  // R4 / R5: spikes last one cycle and never come back to back
  assert_spike_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    spike_q |=> !spike_q);

  // R2: no spike follows an idle cycle
  assert_idle_nospike_R2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> !spike_q);
endmodule

// File: tb/sim_adaptive_lif_neuron.sv
module sim_adaptive_lif_neuron;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              step_en = 1'b0;
  logic signed [11:0] syn_in = '0;
  logic [7:0]        win_len = 8'd100;
  logic [7:0]        act_hi = 8'd200;
  logic [7:0]        act_lo = 8'd0;
  logic              spike;
  logic [8:0]        mem_out;
  logic [8:0]        thr_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adaptive_lif_neuron u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .syn_in(syn_in),
    .win_len(win_len), .act_hi(act_hi), .act_lo(act_lo),
    .spike(spike), .mem_out(mem_out), .thr_out(thr_out)
  );

  typedef struct packed {
    logic              st;
    logic signed [11:0] inp;
    logic              sp;
    logic [8:0]        mem;
  } vec_t;

  localparam int NV = 17;
  // leak shift 3, refractory 2 steps, threshold fixed at 128 in this phase
  localparam vec_t TBL [NV] = '{
    '{1'b1,  12'sd64,   1'b0, 9'd64},   // R3 integrate from rest
    '{1'b1,  12'sd40,   1'b0, 9'd96},   // R3 leak 8 then add
    '{1'b0,  12'sd500,  1'b0, 9'd96},   // R2 idle, input ignored
    '{1'b1, -12'sd20,   1'b0, 9'd64},   // R3 negative input
    '{1'b1, -12'sd100,  1'b0, 9'd0},    // R3 floor at zero
    '{1'b1,  12'sd0,    1'b0, 9'd0},    // R3 rest stays rest
    '{1'b1,  12'sd128,  1'b0, 9'd128},  // R4 equal does not fire
    '{1'b1,  12'sd1,    1'b0, 9'd113},  // R3 leak 16
    '{1'b1,  12'sd30,   1'b1, 9'd0},    // R4 129 fires
    '{1'b1,  12'sd2000, 1'b0, 9'd0},    // R5 refractory step 1
    '{1'b1,  12'sd2000, 1'b0, 9'd0},    // R5 refractory step 2
    '{1'b1,  12'sd100,  1'b0, 9'd100},  // R5 released
    '{1'b1,  12'sd2047, 1'b1, 9'd0},    // R6 would wrap to 87
    '{1'b0,  12'sd2047, 1'b0, 9'd0},    // R2 idle clears spike
    '{1'b1,  12'sd2047, 1'b0, 9'd0},    // R5 refractory after idle
    '{1'b1,  12'sd2047, 1'b0, 9'd0},    // R5
    '{1'b1,  12'sd50,   1'b0, 9'd50}    // R3
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_step(input logic st, input logic signed [11:0] v);
    @(negedge clk);
    step_en = st;
    syn_in  = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset membrane", int'(mem_out), 0);
    check("R1 reset threshold", int'(thr_out), 128);
    check("R1 reset spike", int'(spike), 0);
    @(negedge clk);
    rst = 1'b0;

    // Vector table: membrane path, threshold held by act band (R10)
    for (int i = 0; i < NV; i++) begin
      do_step(TBL[i].st, TBL[i].inp);
      check($sformatf("row %0d spike", i), int'(spike), int'(TBL[i].sp));
      check($sformatf("row %0d membrane", i), int'(mem_out), int'(TBL[i].mem));
      check($sformatf("row %0d R10 threshold", i), int'(thr_out), 128);
    end

    // Mid-run reset
    @(negedge clk);
    rst = 1'b1;
    step_en = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid-run reset membrane", int'(mem_out), 0);
    check("R1 mid-run reset threshold", int'(thr_out), 128);
    @(negedge clk);
    rst = 1'b0;

    // Adaptation: fire every 3rd step, window 3 => one firing per window
    win_len = 8'd3;
    act_hi  = 8'd0;
    act_lo  = 8'd0;
    do_step(1'b1, 12'sd2047);
    check("R7 first firing sees empty estimate, spike", int'(spike), 1);
    check("R7 first firing leaves threshold", int'(thr_out), 128);
    do_step(1'b1, 12'sd2047);
    do_step(1'b1, 12'sd2047);
    do_step(1'b1, 12'sd2047);
    check("R8 rise after first window", int'(thr_out), 144);
    do_step(1'b1, 12'sd2047);
    check("R10 no change on refractory step", int'(thr_out), 144);
    for (int s = 6; s <= 30; s++) do_step(1'b1, 12'sd2047);
    check("R8 clamp at maximum", int'(thr_out), 256);

    act_hi = 8'd255;
    act_lo = 8'd5;
    do_step(1'b1, 12'sd2047);
    check("R9 fall by one step", int'(thr_out), 240);
    for (int s = 32; s <= 70; s++) do_step(1'b1, 12'sd2047);
    check("R9 clamp at minimum", int'(thr_out), 80);

    // In-band activity: firings continue, threshold holds
    act_lo = 8'd1;
    act_hi = 8'd1;
    for (int s = 0; s < 3; s++) do_step(1'b1, 12'sd2047);
    check("R10 in-band firing holds threshold", int'(thr_out), 80);
    act_hi = 8'd0;
    for (int s = 0; s < 3; s++) do_step(1'b1, 12'sd2047);
    check("R8 rise from minimum", int'(thr_out), 96);
    do_step(1'b0, 12'sd2047);
    check("R2 idle keeps threshold", int'(thr_out), 96);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule